// File: doc/BRIEF.md
# Word FIFO Pair with Threshold Ready Flags

This block holds the two data queues that sit between a host register interface and a serial shifter. The transmit queue takes 32-bit words from the host and hands them to the shifter. The receive queue takes words from the shifter and hands them to the host. Each queue holds two words, which is eight bytes. Each queue reports full and empty, and keeps sticky error bits for a push into a full queue and a pop from an empty queue. Each queue also raises a ready flag. The ready flag compares the queue's byte level against a 3-bit threshold taken from configuration.

Software normally programs the receive threshold to one less than the word size in bytes, and the transmit threshold to seven minus the word size. With 4-byte words this means ready is raised as soon as one whole word can be read, or as soon as one whole word of space is free.

A flush request empties both queues and clears their error bits. Its busy indication drops by itself once the work is done. A software reset input, held high, keeps both queues and all flags in their idle state. The asynchronous reset input is released synchronously inside the block.

Top module: `spi_fifo_pair`

## Requirements
- R1: After reset, both queues are empty, all error bits are 0, `flush_busy` is 0 and both data outputs read 0.
- R2: Words pushed by the host come out at `s_pop_data` in push order; the data appears on the clock edge that accepts the pop and is held until the next accepted pop.
- R3: Words pushed by the shifter come out at `h_pop_data` in push order, with the same timing as R2.
- R4: Status bit 7 is set when the transmit queue holds 2 words and bit 6 is set when it holds none. Bits 5 and 4 give the same two indications for the receive queue. Bits 1:0 always read 0.
- R5: A push into a full queue drops the word and sets the overflow bit: status bit 11 for the transmit queue, bit 9 for the receive queue.
- R6: A pop from an empty queue sets the underflow bit (status bit 10 for transmit, bit 8 for receive). That queue's data output keeps its last value.
- R7: Overflow and underflow bits stay set through later pushes and pops until a flush or a reset.
- R8: Status bit 2 is 1 exactly when 4 × (receive words held) is greater than `rd_thresh`.
- R9: Status bit 3 is 1 exactly when 8 − 4 × (transmit words held) is greater than `wr_thresh`.
- R10: A one-cycle `flush_req` makes `flush_busy` read 1 for one cycle. At the end of that cycle both queues are empty, all four error bits are 0 and `flush_busy` is 0 again. A push made during the busy cycle is dropped.
- R11: While `soft_rst` is held, both queues read empty, the error bits read 0, and pushes have no effect. Normal operation resumes after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Held software reset of queues and flags |
| flush_req | input | 1 | Request to empty both queues |
| flush_busy | output | 1 | Flush in progress; clears itself |
| wr_thresh | input | 3 | Transmit-queue free-space threshold in bytes |
| rd_thresh | input | 3 | Receive-queue fill threshold in bytes |
| h_push | input | 1 | Host pushes a word into the transmit queue |
| h_push_data | input | 32 | Word pushed by the host |
| h_pop | input | 1 | Host pops a word from the receive queue |
| h_pop_data | output | 32 | Last word popped from the receive queue |
| s_pop | input | 1 | Shifter pops a word from the transmit queue |
| s_pop_data | output | 32 | Last word popped from the transmit queue |
| s_push | input | 1 | Shifter pushes a word into the receive queue |
| s_push_data | input | 32 | Word pushed by the shifter |
| status | output | 12 | Flag vector; bit positions given in R4 to R9 |

## Verification
A corrupted pointer or level counter shows up at the ports within a single cycle. The full, empty and ready bits are decoded from the level counter every cycle, and the next popped word would be out of order or duplicated. A lost sticky bit is visible in the very next status sample, because the bench keeps its own model of all four error bits across later traffic. A flush or software reset that fails to clear state is caught in the cycle after the busy or reset cycle, from both the status vector and the following pop data.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  localparam int WORD_W     = 32;
  localparam int WORD_BYTES = 4;
  localparam int FIFO_WORDS = 2;
  localparam int THR_W      = 3;
  localparam int STAT_W     = 12;

  // status bit positions (decoded by the register block)
  localparam int ST_TX_OVF   = 11;
  localparam int ST_TX_UNF   = 10;
  localparam int ST_RX_OVF   = 9;
  localparam int ST_RX_UNF   = 8;
  localparam int ST_TX_FULL  = 7;
  localparam int ST_TX_EMPTY = 6;
  localparam int ST_RX_FULL  = 5;
  localparam int ST_RX_EMPTY = 4;
  localparam int ST_TX_READY = 3;
  localparam int ST_RX_READY = 2;

  typedef struct packed {
    logic full;
    logic empty;
    logic ovf;
    logic unf;
    logic ready;
  } fifo_flags_t;
endpackage

// File: rtl/sfp_rst_sync.sv
module sfp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/sfp_fifo_core.sv
module sfp_fifo_core #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 2,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] pop_data,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty,
  output logic             ovf,
  output logic             unf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0]    wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             ovf_q, ovf_d, unf_q, unf_d;
  logic [WIDTH-1:0] dout_q, dout_d;
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic             push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full && !clr;
  assign pop_ok  = pop && !empty && !clr;

  // storage: one explicit enable per entry
  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic we;
    assign we = push_ok && (wp_q == AW'(i));
    always_ff @(posedge clk) begin
      if (we) mem_q[i] <= push_data;
    end
  end

  always_comb begin
    wp_d   = wp_q;
    rp_d   = rp_q;
    cnt_d  = cnt_q;
    ovf_d  = ovf_q;
    unf_d  = unf_q;
    dout_d = dout_q;
    if (clr) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
      ovf_d = 1'b0;
      unf_d = 1'b0;
    end else begin
      if (push_ok) wp_d = ptr_inc(wp_q);
      if (pop_ok) begin
        rp_d   = ptr_inc(rp_q);
        dout_d = mem_q[rp_q];
      end
      cnt_d = cnt_q + CW'(push_ok) - CW'(pop_ok);
      if (push && full)  ovf_d = 1'b1;
      if (pop && empty)  unf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      rp_q   <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
      dout_q <= '0;
    end else begin
      wp_q   <= wp_d;
      rp_q   <= rp_d;
      cnt_q  <= cnt_d;
      ovf_q  <= ovf_d;
      unf_q  <= unf_d;
      dout_q <= dout_d;
    end
  end

  assign pop_data = dout_q;
  assign count    = cnt_q;
  assign ovf      = ovf_q;
  assign unf      = unf_q;

  // R4: level never exceeds capacity
  p_level_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R5: push into full queue is dropped and flagged
  p_drop_on_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !clr) |=> (cnt_q == $past(cnt_q)) && ovf_q);

  // R6: pop from empty keeps last data
  p_hold_on_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !clr) |=> $stable(dout_q) && unf_q);

  // R7: error bits sticky until clear
  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr) |=> ovf_q);
  p_unf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (unf_q && !clr) |=> unf_q);

  // R10: clear leaves queue empty and error free
  p_clear_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (empty && !ovf_q && !unf_q));
endmodule

// File: rtl/sfp_level_flag.sv
module sfp_level_flag #(
  parameter int DEPTH      = 2,
  parameter int WORD_BYTES = 4,
  parameter int TW         = 3,
  parameter int CW         = $clog2(DEPTH + 1),
  parameter bit FREE_MODE  = 1'b0
) (
  input  logic [CW-1:0] count,
  input  logic [TW-1:0] thr,
  output logic          ready
);
  localparam int TOTAL = DEPTH * WORD_BYTES;
  localparam int FBW   = $clog2(TOTAL + 1);
  localparam int CMPW  = (FBW > TW) ? FBW : TW;

  logic [CMPW-1:0] fill_bytes;
  logic [CMPW-1:0] thr_ext;

  assign fill_bytes = CMPW'(count) * CMPW'(WORD_BYTES);
  assign thr_ext    = CMPW'(thr);

  if (FREE_MODE) begin : g_free
    logic [CMPW-1:0] free_bytes;
    assign free_bytes = CMPW'(TOTAL) - fill_bytes;
    assign ready      = free_bytes > thr_ext;
  end else begin : g_fill
    assign ready = fill_bytes > thr_ext;
  end
endmodule

// File: rtl/sfp_flush_ctl.sv
module sfp_flush_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic flush_req,
  output logic busy,
  output logic clr
);
  logic busy_q, busy_d;

  always_comb begin
    busy_d = flush_req && !soft_rst;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  assign busy = busy_q;
  assign clr  = busy_q || soft_rst;

  // R10: busy drops once the request is gone
  p_flush_self_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !flush_req) |=> !busy_q);
  // R10: busy only follows a request
  p_flush_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(flush_req));
endmodule

// File: rtl/spi_fifo_pair.sv
module spi_fifo_pair #(
  parameter int WIDTH      = sfp_pkg::WORD_W,
  parameter int DEPTH      = sfp_pkg::FIFO_WORDS,
  parameter int WORD_BYTES = sfp_pkg::WORD_BYTES,
  parameter int TW         = sfp_pkg::THR_W,
  parameter int SW         = sfp_pkg::STAT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             flush_req,
  output logic             flush_busy,
  input  logic [TW-1:0]    wr_thresh,
  input  logic [TW-1:0]    rd_thresh,
  input  logic             h_push,
  input  logic [WIDTH-1:0] h_push_data,
  input  logic             h_pop,
  output logic [WIDTH-1:0] h_pop_data,
  input  logic             s_pop,
  output logic [WIDTH-1:0] s_pop_data,
  input  logic             s_push,
  input  logic [WIDTH-1:0] s_push_data,
  output logic [SW-1:0]    status
);
  import sfp_pkg::*;
  localparam int CW = $clog2(DEPTH + 1);

  logic          rst_i_n;
  logic          clr;
  logic [CW-1:0] tx_cnt, rx_cnt;
  fifo_flags_t   tx_f, rx_f;

  sfp_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  sfp_flush_ctl u_flush (
    .clk(clk), .rst_n(rst_i_n), .soft_rst(soft_rst),
    .flush_req(flush_req), .busy(flush_busy), .clr(clr)
  );

  sfp_fifo_core #(.WIDTH(WIDTH), .DEPTH(DEPTH), .CW(CW)) u_tx (
    .clk(clk), .rst_n(rst_i_n), .clr(clr),
    .push(h_push), .push_data(h_push_data),
    .pop(s_pop), .pop_data(s_pop_data), .count(tx_cnt),
    .full(tx_f.full), .empty(tx_f.empty), .ovf(tx_f.ovf), .unf(tx_f.unf)
  );

  sfp_fifo_core #(.WIDTH(WIDTH), .DEPTH(DEPTH), .CW(CW)) u_rx (
    .clk(clk), .rst_n(rst_i_n), .clr(clr),
    .push(s_push), .push_data(s_push_data),
    .pop(h_pop), .pop_data(h_pop_data), .count(rx_cnt),
    .full(rx_f.full), .empty(rx_f.empty), .ovf(rx_f.ovf), .unf(rx_f.unf)
  );

  sfp_level_flag #(.DEPTH(DEPTH), .WORD_BYTES(WORD_BYTES), .TW(TW),
                   .CW(CW), .FREE_MODE(1'b1)) u_tx_rdy (
    .count(tx_cnt), .thr(wr_thresh), .ready(tx_f.ready)
  );

  sfp_level_flag #(.DEPTH(DEPTH), .WORD_BYTES(WORD_BYTES), .TW(TW),
                   .CW(CW), .FREE_MODE(1'b0)) u_rx_rdy (
    .count(rx_cnt), .thr(rd_thresh), .ready(rx_f.ready)
  );

  always_comb begin
    status              = '0;
    status[ST_TX_OVF]   = tx_f.ovf;
    status[ST_TX_UNF]   = tx_f.unf;
    status[ST_RX_OVF]   = rx_f.ovf;
    status[ST_RX_UNF]   = rx_f.unf;
    status[ST_TX_FULL]  = tx_f.full;
    status[ST_TX_EMPTY] = tx_f.empty;
    status[ST_RX_FULL]  = rx_f.full;
    status[ST_RX_EMPTY] = rx_f.empty;
    status[ST_TX_READY] = tx_f.ready;
    status[ST_RX_READY] = rx_f.ready;
  end

  // R4: a queue is never full and empty at once
  p_flags_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(tx_f.full && tx_f.empty) && !(rx_f.full && rx_f.empty));

  // R11: held software reset keeps queues idle
  p_soft_idle_r11: assert property (@(posedge clk) disable iff (!rst_i_n)
    (soft_rst && $past(soft_rst)) |-> (tx_f.empty && rx_f.empty && !tx_f.ovf && !rx_f.ovf));
endmodule

// File: tb/spi_fifo_pair_test.sv
`timescale 1ns/1ps
module spi_fifo_pair_test;
  logic        clk = 1'b0;
  logic        rst_n, soft_rst, flush_req;
  logic        flush_busy;
  logic [2:0]  wr_thresh, rd_thresh;
  logic        h_push, h_pop, s_pop, s_push;
  logic [31:0] h_push_data, s_push_data, h_pop_data, s_pop_data;
  logic [11:0] status;

  int checks = 0;
  int errors = 0;

  // scoreboard model
  logic [31:0] wq[$];
  logic [31:0] rq[$];
  bit wovf, wunf, rovf, runf;
  bit sr_m;
  logic [31:0] tx_last, rx_last, tx_exp, rx_exp;
  bit tx_chk, rx_chk;
  string tx_tag, rx_tag;

  always #2.5 clk = ~clk;

  spi_fifo_pair uut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .flush_req(flush_req),
    .flush_busy(flush_busy), .wr_thresh(wr_thresh), .rd_thresh(rd_thresh),
    .h_push(h_push), .h_push_data(h_push_data), .h_pop(h_pop),
    .h_pop_data(h_pop_data), .s_pop(s_pop), .s_pop_data(s_pop_data),
    .s_push(s_push), .s_push_data(s_push_data), .status(status)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_stat();
    logic [11:0] s = '0;
    int wc = wq.size();
    int rc = rq.size();
    s[11] = wovf; s[10] = wunf; s[9] = rovf; s[8] = runf;
    s[7] = (wc == 2); s[6] = (wc == 0);
    s[5] = (rc == 2); s[4] = (rc == 0);
    s[3] = ((8 - 4 * wc) > int'(wr_thresh));
    s[2] = ((4 * rc) > int'(rd_thresh));
    return s;
  endfunction

  task automatic chk_stat(string tag);
    check(tag, {20'd0, status}, {20'd0, exp_stat()});
  endtask

  task automatic host_push(logic [31:0] v);
    @(negedge clk); h_push = 1'b1; h_push_data = v;
    @(posedge clk); #1; h_push = 1'b0;
    if (!sr_m) begin
      if (wq.size() < 2) wq.push_back(v); else wovf = 1'b1;
    end
  endtask

  task automatic shift_push(logic [31:0] v);
    @(negedge clk); s_push = 1'b1; s_push_data = v;
    @(posedge clk); #1; s_push = 1'b0;
    if (!sr_m) begin
      if (rq.size() < 2) rq.push_back(v); else rovf = 1'b1;
    end
  endtask

  task automatic shift_pop();
    @(negedge clk); s_pop = 1'b1;
    @(posedge clk); #1; s_pop = 1'b0;
    if (wq.size() > 0) begin tx_last = wq.pop_front(); tx_tag = "R2"; end
    else begin wunf = 1'b1; tx_tag = "R6"; end
    tx_exp = tx_last; tx_chk = 1'b1;
  endtask

  task automatic host_pop();
    @(negedge clk); h_pop = 1'b1;
    @(posedge clk); #1; h_pop = 1'b0;
    if (rq.size() > 0) begin rx_last = rq.pop_front(); rx_tag = "R3"; end
    else begin runf = 1'b1; rx_tag = "R6"; end
    rx_exp = rx_last; rx_chk = 1'b1;
  endtask

  // monitor: compares popped data against the scoreboard
  always @(negedge clk) begin
    if (tx_chk) begin check(tx_tag, s_pop_data, tx_exp); tx_chk = 1'b0; end
    if (rx_chk) begin check(rx_tag, h_pop_data, rx_exp); rx_chk = 1'b0; end
  end

  task automatic do_flush(bit push_during);
    @(negedge clk); flush_req = 1'b1;
    @(posedge clk); #1; flush_req = 1'b0;
    @(negedge clk);
    check("R10 busy", {31'd0, flush_busy}, 32'd1);
    if (push_during) begin h_push = 1'b1; h_push_data = 32'hDEAD_0001; end
    @(posedge clk); #1; h_push = 1'b0;
    wq.delete(); rq.delete();
    wovf = 0; wunf = 0; rovf = 0; runf = 0;
    check("R10 done", {31'd0, flush_busy}, 32'd0);
    chk_stat("R10 stat");
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; soft_rst = 1'b0; flush_req = 1'b0;
    h_push = 0; h_pop = 0; s_push = 0; s_pop = 0;
    h_push_data = '0; s_push_data = '0;
    wr_thresh = 3'd3; rd_thresh = 3'd3;
    tx_last = '0; rx_last = '0; tx_chk = 0; rx_chk = 0; sr_m = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 stat", {20'd0, status}, 32'h58);
    check("R1 busy", {31'd0, flush_busy}, 32'd0);
    check("R1 data", s_pop_data | h_pop_data, 32'd0);

    // transmit queue: fill, overflow, drain, underflow
    host_push(32'hA1A1_0001); chk_stat("R9 one word");
    host_push(32'hB2B2_0002); chk_stat("R4 tx full");
    host_push(32'hC3C3_0003); chk_stat("R5 tx ovf");
    shift_pop(); shift_pop(); chk_stat("R4 tx empty");
    shift_pop(); chk_stat("R6 tx unf");
    host_push(32'hD4D4_0004); chk_stat("R7 sticky");
    shift_pop(); chk_stat("R7 sticky");
    do_flush(1'b0);

    // receive queue
    shift_push(32'hE5E5_0005); chk_stat("R8 rx ready");
    shift_push(32'hF6F6_0006); chk_stat("R4 rx full");
    shift_push(32'h0707_0007); chk_stat("R5 rx ovf");
    host_pop(); host_pop(); host_pop(); chk_stat("R6 rx unf");
    do_flush(1'b0);

    // thresholds
    rd_thresh = 3'd4; #1; chk_stat("R8 thr4 empty");
    shift_push(32'h1111_0008); chk_stat("R8 thr4 one");
    shift_push(32'h2222_0009); chk_stat("R8 thr4 two");
    wr_thresh = 3'd0; #1; chk_stat("R9 thr0 empty");
    host_push(32'h3333_000A); chk_stat("R9 thr0 one");
    host_push(32'h4444_000B); chk_stat("R9 thr0 full");
    wr_thresh = 3'd7; #1; chk_stat("R9 thr7 full");
    shift_pop(); chk_stat("R9 thr7 one");
    shift_pop(); chk_stat("R9 thr7 empty");
    host_pop(); host_pop();
    wr_thresh = 3'd3; rd_thresh = 3'd3;

    // flush with a push during the busy cycle: dropped
    host_push(32'h5555_000C);
    do_flush(1'b1);
    shift_pop(); chk_stat("R10 dropped");
    do_flush(1'b0);

    // soft reset held
    host_push(32'h6666_000D);
    shift_push(32'h7777_000E);
    @(negedge clk); soft_rst = 1'b1; sr_m = 1;
    @(posedge clk); #1;
    wq.delete(); rq.delete();
    chk_stat("R11 idle");
    host_push(32'h8888_000F); chk_stat("R11 ignore");
    shift_push(32'h9999_0010); chk_stat("R11 ignore");
    @(negedge clk); soft_rst = 1'b0; sr_m = 0;
    host_push(32'hAAAA_0011); chk_stat("R11 resume");
    shift_pop(); chk_stat("R11 resume");

    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule